// File: doc/BRIEF.md
# UART Modem Control Path with Local Loopback

This block holds the modem control word of a 16550-class serial port and routes the serial and modem lines according to that word. In normal operation the transmit serial bit goes out on the serial output pin, the receive pin feeds the receiver, and four active-low modem output pins follow the control bits. Four active-low modem input pins are synchronized and reported as asserted-high status levels. Each line also has a sticky change flag, and these flags are the sources of the modem status interrupt.

Setting the loopback bit turns the block into a diagnostic path. The transmit bit is fed straight back to the receiver and the external receive pin is ignored. The serial output pin and all modem output pins rest at their inactive high level. The status levels are taken from the control bits themselves instead of the external pins, so software can toggle a control bit and observe the matching status and change flag. Two control bits also select one of three automatic flow control modes for the transmitter and receiver logic around this block.

Top module: `uart_modem_ctl`

## Requirements
- R1: While loopback (control bit 4) is set, `sout_pin` is 1 whatever `tx_bit` holds; with loopback clear, `sout_pin` equals `tx_bit`.
- R2: While loopback is set, `rx_bit` equals `tx_bit` and `sin_pin` has no effect; with loopback clear, `rx_bit` equals `sin_pin`.
- R3: While loopback is set, `dtr_n`, `rts_n`, `out1_n` and `out2_n` are all 1 regardless of the control bits.
- R4: With loopback clear, control bit 0 drives `dtr_n`, bit 1 `rts_n`, bit 2 `out1_n` and bit 3 `out2_n`, each active low (bit 1 gives pin 0), from the cycle after the write.
- R5: While loopback is set, the status levels come from the control bits (bit 0 gives DSR, bit 1 CTS, bit 2 RI, bit 3 DCD), one cycle after the control register changes, and the external modem input pins have no effect.
- R6: With loopback clear, each status level is the inverse of its input pin. A pin change shows in the status three clock edges after it is applied: two synchronizer flops and the status register.
- R7: `modem_stat` carries levels in bits 7..4 (DCD, RI, DSR, CTS) and change flags in bits 3..0 (bit 3 DCD, bit 2 RI, bit 1 DSR, bit 0 CTS). A flag sets in the same cycle its level changes and stays set without a read.
- R8: A one-cycle `stat_rd` clears every change flag whose level did not change in that same cycle; the levels are unaffected.
- R9: Control bit 5 set with bit 1 set enables both `auto_rts_en` and `auto_cts_en`. Bit 5 set with bit 1 clear enables `auto_cts_en` only. Bit 5 clear disables both, whatever bit 1 holds.
- R10: After reset the control word is 0: all modem output pins are 1, `modem_stat` is 0 and both flow enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 6 | Control word: 0 DTR, 1 RTS, 2 OUT1, 3 OUT2, 4 loopback, 5 auto flow |
| stat_rd | input | 1 | Status read strobe; clears change flags |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| dcd_n | input | 1 | Carrier-detect pin, active low |
| ri_n | input | 1 | Ring-indicator pin, active low |
| sin_pin | input | 1 | External serial receive pin |
| tx_bit | input | 1 | Serial output of the transmit shift register |
| sout_pin | output | 1 | External serial transmit pin |
| rx_bit | output | 1 | Serial input to the receive shift register |
| dtr_n | output | 1 | Terminal-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| out1_n | output | 1 | User output 1, active low |
| out2_n | output | 1 | User output 2, active low |
| modem_stat | output | 8 | Status levels (7..4) and change flags (3..0) |
| auto_rts_en | output | 1 | Automatic RTS flow control enable |
| auto_cts_en | output | 1 | Automatic CTS flow control enable |

## Verification
A wrong control word shows on the pins and flow enables in the cycle after the write. The pin and serial routing is combinational, so a corrupted loopback bit appears on `sout_pin`, `rx_bit` and the modem output pins at once. A wrong synchronizer or status register shows up as a status level arriving at the wrong edge, so the bench samples exactly two and three edges after a pin change. A stuck or lost change flag becomes visible on the next status sample, and a flag that is not cleared shows right after a read. In loopback, each line is driven through its own control bit, so a swapped mapping shows as the wrong status bit within one cycle.

// File: rtl/uart_mctl_pkg.sv
package uart_mctl_pkg;

    localparam int CTL_W     = 6;
    localparam int NUM_LINES = 4;
    localparam int STAT_W    = 2 * NUM_LINES;

    // Control word; bit positions matter (flow decode uses bits 1 and 5).
    typedef struct packed {
        logic afe;   // bit 5
        logic loop;  // bit 4
        logic out2;  // bit 3
        logic out1;  // bit 2
        logic rts;   // bit 1
        logic dtr;   // bit 0
    } mctl_t;

    // Modem lines, asserted high, in status-word order.
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } mlines_t;

    typedef enum logic [1:0] {
        FLOW_OFF      = 2'b00,
        FLOW_CTS_ONLY = 2'b01,
        FLOW_FULL     = 2'b11
    } flow_e;

    function automatic flow_e flow_decode(input mctl_t c);
        if (!c.afe)     return FLOW_OFF;
        else if (c.rts) return FLOW_FULL;
        else            return FLOW_CTS_ONLY;
    endfunction

    // Diagnostic wiring of control outputs onto status inputs.
    function automatic mlines_t loop_lines(input mctl_t c);
        mlines_t l;
        l.dsr = c.dtr;
        l.cts = c.rts;
        l.ri  = c.out1;
        l.dcd = c.out2;
        return l;
    endfunction

endpackage

// File: rtl/uart_mctl_sync.sv
module uart_mctl_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= '0;
                    else     stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= '0;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/uart_mctl_route.sv
module uart_mctl_route
    import uart_mctl_pkg::*;
(
    input  mctl_t   ctl,
    input  mlines_t ext_sync,
    input  logic    tx_bit,
    input  logic    sin_pin,
    output logic    sout_pin,
    output logic    rx_bit,
    output logic    dtr_n,
    output logic    rts_n,
    output logic    out1_n,
    output logic    out2_n,
    output mlines_t line_sel,
    output flow_e   flow
);
    always_comb begin
        if (ctl.loop) begin
            sout_pin = 1'b1;
            rx_bit   = tx_bit;
            dtr_n    = 1'b1;
            rts_n    = 1'b1;
            out1_n   = 1'b1;
            out2_n   = 1'b1;
            line_sel = loop_lines(ctl);
        end else begin
            sout_pin = tx_bit;
            rx_bit   = sin_pin;
            dtr_n    = ~ctl.dtr;
            rts_n    = ~ctl.rts;
            out1_n   = ~ctl.out1;
            out2_n   = ~ctl.out2;
            line_sel = ext_sync;
        end
        flow = flow_decode(ctl);
    end
endmodule

// File: rtl/uart_mctl_status.sv
module uart_mctl_status
    import uart_mctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  mlines_t line_sel,
    input  logic    clr,
    output mlines_t level,
    output mlines_t delta
);
    mlines_t change;

    always_comb change = line_sel ^ level;

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= '0;
            delta <= '0;
        end else begin
            level <= line_sel;
            // a change in the read cycle still gets flagged
            delta <= (clr ? mlines_t'('0) : delta) | change;
        end
    end
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
    import uart_mctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ctl_wr,
    input  logic [5:0]  ctl_wdata,
    input  logic        stat_rd,
    input  logic        cts_n,
    input  logic        dsr_n,
    input  logic        dcd_n,
    input  logic        ri_n,
    input  logic        sin_pin,
    input  logic        tx_bit,
    output logic        sout_pin,
    output logic        rx_bit,
    output logic        dtr_n,
    output logic        rts_n,
    output logic        out1_n,
    output logic        out2_n,
    output logic [7:0]  modem_stat,
    output logic        auto_rts_en,
    output logic        auto_cts_en
);
    mctl_t   ctl_q;
    mlines_t ext_raw, ext_sync, line_sel, level, delta;
    flow_e   flow;

    always_ff @(posedge clk) begin
        if (rst)         ctl_q <= '0;
        else if (ctl_wr) ctl_q <= mctl_t'(ctl_wdata);
    end

    always_comb begin
        ext_raw.cts = ~cts_n;
        ext_raw.dsr = ~dsr_n;
        ext_raw.ri  = ~ri_n;
        ext_raw.dcd = ~dcd_n;
    end

    uart_mctl_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ext_raw),
        .q   (ext_sync)
    );

    uart_mctl_route u_route (
        .ctl      (ctl_q),
        .ext_sync (ext_sync),
        .tx_bit   (tx_bit),
        .sin_pin  (sin_pin),
        .sout_pin (sout_pin),
        .rx_bit   (rx_bit),
        .dtr_n    (dtr_n),
        .rts_n    (rts_n),
        .out1_n   (out1_n),
        .out2_n   (out2_n),
        .line_sel (line_sel),
        .flow     (flow)
    );

    uart_mctl_status u_status (
        .clk      (clk),
        .rst      (rst),
        .line_sel (line_sel),
        .clr      (stat_rd),
        .level    (level),
        .delta    (delta)
    );

    assign modem_stat  = {level, delta};
    assign auto_cts_en = flow[0];
    assign auto_rts_en = flow[1];
endmodule

// File: rtl/uart_modem_ctl_chk.sv
module uart_modem_ctl_chk (
    input logic       clk,
    input logic       rst,
    input logic       ctl_wr,
    input logic [5:0] ctl_wdata,
    input logic       stat_rd,
    input logic       tx_bit,
    input logic       sout_pin,
    input logic       rx_bit,
    input logic       dtr_n,
    input logic       rts_n,
    input logic       out1_n,
    input logic       out2_n,
    input logic [7:0] modem_stat,
    input logic       auto_rts_en,
    input logic       auto_cts_en
);
    // R1
    p_loop_sout_high_r1: assert property (@(posedge clk) disable iff (rst)
        ctl_wr && ctl_wdata[4] |=> sout_pin);

    // R2
    p_loop_rx_echo_r2: assert property (@(posedge clk) disable iff (rst)
        ctl_wr && ctl_wdata[4] |=> rx_bit == tx_bit);

    // R3
    p_loop_pins_idle_r3: assert property (@(posedge clk) disable iff (rst)
        ctl_wr && ctl_wdata[4] |=> dtr_n && rts_n && out1_n && out2_n);

    // R7: flags stay set until a read
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        !stat_rd |=> (modem_stat[3:0] & $past(modem_stat[3:0])) == $past(modem_stat[3:0]));

    // R8: after a read only lines that just changed remain flagged
    p_read_clears_r8: assert property (@(posedge clk) disable iff (rst)
        stat_rd |=> (modem_stat[3:0] & ~(modem_stat[7:4] ^ $past(modem_stat[7:4]))) == 4'b0);

    // R9
    p_flow_decode_r9: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |=> auto_cts_en == $past(ctl_wdata[5]) &&
                   auto_rts_en == ($past(ctl_wdata[5]) && $past(ctl_wdata[1])));

    p_rts_needs_cts_r9: assert property (@(posedge clk) disable iff (rst)
        auto_rts_en |-> auto_cts_en);
endmodule

bind uart_modem_ctl uart_modem_ctl_chk u_chk (.*);

// File: tb/uart_modem_ctl_tb.sv
module uart_modem_ctl_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_wr = 1'b0;
    logic [5:0] ctl_wdata = '0;
    logic       stat_rd = 1'b0;
    logic       cts_n = 1'b1, dsr_n = 1'b1, dcd_n = 1'b1, ri_n = 1'b1;
    logic       sin_pin = 1'b1, tx_bit = 1'b1;
    logic       sout_pin, rx_bit, dtr_n, rts_n, out1_n, out2_n;
    logic [7:0] modem_stat;
    logic       auto_rts_en, auto_cts_en;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_modem_ctl u_dut (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .stat_rd(stat_rd), .cts_n(cts_n), .dsr_n(dsr_n), .dcd_n(dcd_n),
        .ri_n(ri_n), .sin_pin(sin_pin), .tx_bit(tx_bit),
        .sout_pin(sout_pin), .rx_bit(rx_bit), .dtr_n(dtr_n), .rts_n(rts_n),
        .out1_n(out1_n), .out2_n(out2_n), .modem_stat(modem_stat),
        .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_ctl(input logic [5:0] v);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic read_stat();
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    function automatic logic [7:0] pins();
        return {4'b0, out2_n, out1_n, rts_n, dtr_n};
    endfunction

    task automatic t_reset();
        check("R10 pins", pins(), 8'h0F);
        check("R10 stat", modem_stat, 8'h00);
        check("R10 flow", {6'b0, auto_rts_en, auto_cts_en}, 8'h00);
        tx_bit = 1'b0; sin_pin = 1'b1; tick(1);
        check("R1 sout follows tx", {7'b0, sout_pin}, 8'h00);
        check("R2 rx follows sin", {7'b0, rx_bit}, 8'h01);
    endtask

    task automatic t_outputs();
        write_ctl(6'h05);
        check("R4 dtr/out1 low", pins(), 8'h0A);
        write_ctl(6'h0A);
        check("R4 rts/out2 low", pins(), 8'h05);
        write_ctl(6'h00);
        check("R4 all released", pins(), 8'h0F);
    endtask

    task automatic t_loop_serial();
        write_ctl(6'h1F);
        check("R3 pins idle in loop", pins(), 8'h0F);
        tx_bit = 1'b0; sin_pin = 1'b1; tick(1);
        check("R1 sout high in loop", {7'b0, sout_pin}, 8'h01);
        check("R2 rx from tx", {7'b0, rx_bit}, 8'h00);
        tx_bit = 1'b1; sin_pin = 1'b0; tick(1);
        check("R2 rx from tx, sin ignored", {7'b0, rx_bit}, 8'h01);
        write_ctl(6'h00);
        tick(1);
        read_stat();
        check("R8 clean before loop map", modem_stat, 8'h00);
    endtask

    task automatic t_loop_status();
        write_ctl(6'h10);
        tick(1);
        cts_n = 1'b0; dsr_n = 1'b0; dcd_n = 1'b0; ri_n = 1'b0;
        tick(4);
        check("R5 ext pins ignored in loop", modem_stat, 8'h00);
        write_ctl(6'h11); tick(1);
        check("R5 dtr->dsr", modem_stat, 8'h22);
        read_stat();
        check("R8 read clears dsr flag", modem_stat, 8'h20);
        write_ctl(6'h12); tick(1);
        check("R5 rts->cts", modem_stat, 8'h13);
        read_stat();
        write_ctl(6'h14); tick(1);
        check("R5 out1->ri", modem_stat, 8'h45);
        read_stat();
        write_ctl(6'h18); tick(1);
        check("R5 out2->dcd", modem_stat, 8'h8C);
        read_stat();
        check("R8 level kept", modem_stat, 8'h80);
        write_ctl(6'h00); tick(1);
        check("R6 leave loop to ext pins", modem_stat, 8'hF7);
        cts_n = 1'b1; dsr_n = 1'b1; dcd_n = 1'b1; ri_n = 1'b1;
        tick(4);
        read_stat();
        check("R8 clean after loop", modem_stat, 8'h00);
    endtask

    task automatic t_ext_sync();
        @(negedge clk);
        cts_n = 1'b0;
        tick(2);
        check("R6 not yet after two edges", modem_stat, 8'h00);
        tick(1);
        check("R6 cts after three edges", modem_stat, 8'h11);
        tick(3);
        check("R7 flag sticky", modem_stat, 8'h11);
        cts_n = 1'b1;
        tick(3);
        check("R7 flag held after release", modem_stat, 8'h01);
        read_stat();
        check("R8 cleared", modem_stat, 8'h00);
        ri_n = 1'b0; dcd_n = 1'b0;
        tick(3);
        check("R6 ri and dcd", modem_stat, 8'hCC);
        read_stat();
        check("R8 levels kept on read", modem_stat, 8'hC0);
        ri_n = 1'b1; dcd_n = 1'b1;
        tick(3);
        read_stat();
        check("R8 clean", modem_stat, 8'h00);
    endtask

    task automatic t_flow();
        write_ctl(6'h22);
        check("R9 full flow", {6'b0, auto_rts_en, auto_cts_en}, 8'h03);
        write_ctl(6'h20);
        check("R9 cts only", {6'b0, auto_rts_en, auto_cts_en}, 8'h01);
        write_ctl(6'h02);
        check("R9 off with rts set", {6'b0, auto_rts_en, auto_cts_en}, 8'h00);
        write_ctl(6'h00);
        check("R9 off", {6'b0, auto_rts_en, auto_cts_en}, 8'h00);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_outputs();
        t_loop_serial();
        t_loop_status();
        t_ext_sync();
        t_flow();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule